// File: doc/BRIEF.md
# Stack Pointer Bound Guard

This block watches every value written into the processor's stack pointer and checks it against two bounds. The upper bound is a ceiling that software can program. The lower bound is a fixed floor, which defaults to 0x0800. A write above the ceiling is an overflow. A write below the floor is an underflow. Either one produces a one-cycle stack error pulse that goes to the trap arbiter. That trap is the hard trap at level 13. The pulse is not gated against other fault sources, so the same offending write can raise an address error from another checker in the same cycle. The arbiter then decides which of the two is served first.

Both comparisons are unsigned and 16 bits wide. They use the new value being written, never the old contents of the stack pointer. Two sticky cause bits record which bound was crossed. Software clears them by writing a 1 to the matching clear bit. The ceiling resets to its largest value, so overflow cannot be flagged until software programs a lower ceiling.

The write strobes carry no data stream, so there is no valid/ready handshake. Each strobe is a plain one-cycle qualifier and cannot be stalled. The block never applies back-pressure, and it accepts a new stack pointer write, ceiling write or clear on every cycle. This block does not block the faulting write and does not service the trap.

Top module: `stack_guard`

## Requirements
- R1: After reset, `stk_err`, `ovf_flag` and `unf_flag` are 0 and the ceiling holds 0xFFFF. With that ceiling, a write of 0xFFFF raises no overflow.
- R2: A stack pointer write whose value is strictly greater than the ceiling sets `stk_err` high in the following cycle and sets `ovf_flag` at the same edge. A value equal to the ceiling raises nothing.
- R3: A stack pointer write whose value is strictly below the floor (0x0800) sets `stk_err` high in the following cycle and sets `unf_flag` at the same edge. A write of exactly 0x0800 raises nothing.
- R4: `stk_err` is high for exactly the one cycle after each offending write. It is low in any cycle that does not follow an offending write, whatever the state of the sticky flags.
- R5: Each sticky flag stays set until a cycle with `clr_we` high and its clear bit set. Bit 0 of `clr_mask` clears `ovf_flag` and bit 1 clears `unf_flag`. A 0 in a clear bit leaves that flag unchanged.
- R6: If a flag is set and cleared in the same cycle, the set wins and the flag ends up 1.
- R7: A ceiling write takes effect for stack pointer writes in later cycles. A stack pointer write in the same cycle as a ceiling write is compared against the old ceiling.
- R8: The comparisons are unsigned. With a ceiling of 0x7FFF, a write of 0xFFFF is an overflow and not an underflow.
- R9: If the ceiling is programmed below the floor, one write can be both over the ceiling and under the floor. That write sets both flags and gives a single `stk_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_we | input | 1 | A stack pointer write occurs this cycle |
| sp_wdata | input | 16 | New stack pointer value being written |
| lim_we | input | 1 | Write strobe for the ceiling register |
| lim_wdata | input | 16 | New ceiling value |
| clr_we | input | 1 | Write strobe for the clear register of the cause flags |
| clr_mask | input | 2 | Write-1-to-clear mask: bit 0 overflow, bit 1 underflow |
| stk_err | output | 1 | One-cycle stack error pulse to the trap arbiter |
| ovf_flag | output | 1 | Sticky cause flag: ceiling exceeded |
| unf_flag | output | 1 | Sticky cause flag: value below floor |

## Verification
A wrong stored ceiling would stay hidden until a stack pointer write lands between the correct ceiling and the wrong one. At that point `stk_err` is wrong on the very next cycle, so the bench sweeps write values closely around both the programmed ceiling and the floor. A sticky flag that is set or lost in error shows on `ovf_flag` or `unf_flag` at the next edge. It stays wrong until the next set or clear, so a stuck or dropped flag can be seen through many following cycles of random traffic. A pulse that is stretched or missing shows up within one cycle of the write that caused it.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
  localparam int unsigned SG_W      = 16;
  localparam int unsigned SG_NCAUSE = 2;
  localparam int unsigned SG_OVF    = 0;
  localparam int unsigned SG_UNF    = 1;
  typedef logic [SG_W-1:0]      sg_word_t;
  typedef logic [SG_NCAUSE-1:0] sg_cause_t;
endpackage

// File: rtl/sg_limit_reg.sv
module sg_limit_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] ceil_q
);
  localparam logic [W-1:0] CEIL_RST = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ceil_q <= CEIL_RST;
    else if (wr_en) ceil_q <= wr_val;
  end

  // R7: the ceiling moves only on its own write strobe
  a_r7_ceil_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ceil_q));
endmodule

// File: rtl/sg_compare.sv
module sg_compare #(
  parameter int unsigned   W     = 16,
  parameter logic [W-1:0]  FLOOR = 16'h0800
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] ceil,
  output logic         over_hit,
  output logic         under_hit
);
  always_comb over_hit = (value > ceil);

  generate
    if (FLOOR == '0) begin : g_no_floor
      always_comb under_hit = 1'b0;
    end else begin : g_floor
      always_comb under_hit = (value < FLOOR);
    end
  endgenerate
endmodule

// File: rtl/sg_cause.sv
module sg_cause #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_en,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic kill;
    always_comb kill = clr_en & clr_vec[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (kill)       flag_q[i] <= 1'b0;
    end

    // R5: a flag stays set unless cleared
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !kill) |=> flag_q[i]);
    // R6: set has priority over clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stack_guard_pkg::*;
#(
  parameter logic [SG_W-1:0] FLOOR = 16'h0800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_we,
  input  logic [SG_W-1:0] sp_wdata,
  input  logic            lim_we,
  input  logic [SG_W-1:0] lim_wdata,
  input  logic            clr_we,
  input  logic [1:0]      clr_mask,
  output logic            stk_err,
  output logic            ovf_flag,
  output logic            unf_flag
);
  sg_word_t  ceil_q;
  logic      over_hit, under_hit;
  sg_cause_t set_vec, flags;
  logic      err_q;

  sg_limit_reg #(.W(SG_W)) u_lim (
    .clk(clk), .rst_n(rst_n), .wr_en(lim_we), .wr_val(lim_wdata), .ceil_q(ceil_q)
  );

  sg_compare #(.W(SG_W), .FLOOR(FLOOR)) u_cmp (
    .value(sp_wdata), .ceil(ceil_q), .over_hit(over_hit), .under_hit(under_hit)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[SG_OVF] = sp_we & over_hit;
    set_vec[SG_UNF] = sp_we & under_hit;
  end

  sg_cause #(.N(SG_NCAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_en(clr_we), .clr_vec(clr_mask), .flag_q(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |set_vec;
  end

  assign stk_err  = err_q;
  assign ovf_flag = flags[SG_OVF];
  assign unf_flag = flags[SG_UNF];

  // R4: a pulse only follows a stack pointer write
  a_r4_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_we |=> !stk_err);
  // R2: overflow write raises the error and the flag
  a_r2_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_wdata > ceil_q) |=> (stk_err && ovf_flag));
  // R3: underflow write raises the error and the flag
  a_r3_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_wdata < FLOOR) |=> (stk_err && unf_flag));
  // R3: a newly set cause flag comes with a pulse
  a_r3_rise_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) || $rose(unf_flag)) |-> stk_err);
endmodule

// File: tb/stack_guard_test.sv
module stack_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FLOOR = 16'h0800;

  logic clk = 0, rst_n = 0;
  logic sp_we = 0, lim_we = 0, clr_we = 0;
  logic [15:0] sp_wdata = 0, lim_wdata = 0;
  logic [1:0] clr_mask = 0;
  logic stk_err, ovf_flag, unf_flag;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_ceil;
  logic m_ovf, m_unf, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_guard uut (
    .clk(clk), .rst_n(rst_n), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .lim_we(lim_we), .lim_wdata(lim_wdata), .clr_we(clr_we), .clr_mask(clr_mask),
    .stk_err(stk_err), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  function automatic logic f_over(input logic [15:0] v, input logic [15:0] c);
    return v > c;
  endfunction
  function automatic logic f_under(input logic [15:0] v);
    return v < FLOOR;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, stk_err,  m_err, "stk_err");
    check(req, ovf_flag, m_ovf, "ovf_flag");
    check(req, unf_flag, m_unf, "unf_flag");
  endtask

  // drive one cycle, update model from pre-edge state, sample after edge
  task automatic cyc(input logic we, input logic [15:0] d, input logic lw,
                     input logic [15:0] ld, input logic cw, input logic [1:0] cm,
                     input string req);
    logic o, u;
    sp_we = we; sp_wdata = d; lim_we = lw; lim_wdata = ld; clr_we = cw; clr_mask = cm;
    o = we & f_over(d, m_ceil);
    u = we & f_under(d);
    m_err = o | u;
    m_ovf = o | (m_ovf & ~(cw & cm[0]));
    m_unf = u | (m_unf & ~(cw & cm[1]));
    if (lw) m_ceil = ld;
    @(posedge clk);
    #(CLK_PERIOD/4);
    sp_we = 0; lim_we = 0; clr_we = 0;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ceil = 16'hFFFF; m_ovf = 0; m_unf = 0; m_err = 0;
    #(CLK_PERIOD*2 + CLK_PERIOD/4);
    check_all("R1");
    rst_n = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    cyc(1, 16'hFFFF, 0, 0, 0, 0, "R1");
    cyc(1, 16'h0800, 0, 0, 0, 0, "R3");
    cyc(1, 16'h07FF, 0, 0, 0, 0, "R3");
    cyc(0, 16'h0000, 0, 0, 0, 0, "R4");
    cyc(0, 16'h0000, 0, 0, 1, 2'b01, "R5");
    cyc(0, 16'h0000, 0, 0, 1, 2'b10, "R5");
    cyc(1, 16'h2000, 1, 16'h1000, 0, 0, "R7");
    cyc(1, 16'h1000, 0, 0, 0, 0, "R2");
    cyc(1, 16'h1001, 0, 0, 0, 0, "R2");
    cyc(1, 16'h1002, 0, 0, 1, 2'b01, "R6");
    cyc(0, 0, 0, 0, 1, 2'b01, "R5");
    cyc(0, 0, 1, 16'h7FFF, 0, 0, "R7");
    cyc(1, 16'hFFFF, 0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 16'h0400, 1, 2'b11, "R5");
    cyc(1, 16'h0600, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 16'h3000, 1, 2'b11, "R5");
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] d;
      logic [1:0] cm;
      int sel = $urandom_range(0, 3);
      if (sel == 0) d = FLOOR + 16'($urandom_range(0, 4)) - 16'd2;
      else if (sel == 1) d = m_ceil + 16'($urandom_range(0, 4)) - 16'd2;
      else d = 16'($urandom);
      cm = 2'($urandom);
      cyc($urandom_range(0, 1) == 1, d,
          $urandom_range(0, 15) == 0, 16'($urandom_range(16'h0600, 16'hFFFF)),
          $urandom_range(0, 7) == 0, cm, "R4");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule